// File: doc/BRIEF.md
# RRAM Program-Verify Sequencer

This block steps one 1T1R resistive memory cell through a forming, set or reset operation. Each attempt drives three voltage codes to external DACs: wordline, bitline and source line. It then raises a write pulse for a programmable number of cycles and asks an external sense path for a verify read. If the verify shows the target resistance state, the operation ends with success. If it does not, the next attempt uses a different voltage point.

The search has two levels. The inner loop raises the wordline code by one step per attempt, from its lower limit to its upper limit. When the wordline range runs out, the outer loop raises the driven line by one step and the wordline starts again at its lower limit. The driven line is the bitline for FORM and SET, and the source line for RESET. When both ranges are used up without success, the block reports failure. Codes are in units of 0.1 V. Setting a limit pair equal gives a fixed single-point operation.

The final voltage codes stay on the outputs after completion so that they can be read back. A short pulse (a few cycles) or a long pulse (hundreds of cycles) is selected through the pulse-length input.

Top module: `rram_pv_seq`

## Requirements
- R1: After reset, busy, done, fail, pulse and vfy_req are 0, and wl_code, bl_code and sl_code are 0.
- R2: The op code is 0 for FORM, 1 for SET and 2 for RESET. For FORM and SET, bl_code carries the line code and sl_code is 0. For RESET, sl_code carries the line code and bl_code is 0.
- R3: Each attempt holds pulse high for exactly pulse_len cycles, or 1 cycle when pulse_len is 0. vfy_req rises in the cycle after pulse falls.
- R4: vfy_req stays high until vfy_ack is sampled high. The voltage codes do not change while pulse or vfy_req is high.
- R5: A verify passes when vfy_lrs is 1 after FORM or SET, and when vfy_lrs is 0 after RESET.
- R6: After a failed verify, if the wordline code plus one step does not exceed wl_max, the next attempt uses that wordline code and the same line code.
- R7: After a failed verify with the wordline at its top, if the line code plus one step does not exceed ln_max, the next attempt uses the line code plus one step and the wordline code wl_min. The first attempt uses wl_min and ln_min.
- R8: After a failed verify with both ranges exhausted, done and fail both go high. The last attempted codes remain on the outputs.
- R9: A passing verify, including one on the final search point, sets done with fail low. The passing codes remain on the outputs.
- R10: start is ignored while busy, and start with op code 3 is ignored.
- R11: done and fail hold until the next accepted start, and they read 0 in the cycle after that start.
- R12: With wl_min equal to wl_max and ln_min equal to ln_max, exactly one attempt is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation when idle |
| op | input | 2 | 0 FORM, 1 SET, 2 RESET, 3 ignored |
| wl_min | input | VW | Lowest wordline code |
| wl_max | input | VW | Highest wordline code |
| ln_min | input | VW | Lowest driven-line code |
| ln_max | input | VW | Highest driven-line code |
| pulse_len | input | CW | Write pulse length in cycles |
| vfy_ack | input | 1 | Verify result valid |
| vfy_lrs | input | 1 | Verify result: 1 means low-resistance state |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation finished (held) |
| fail | output | 1 | Search exhausted without success (held) |
| pulse | output | 1 | Write pulse enable |
| vfy_req | output | 1 | Verify read request |
| wl_code | output | VW | Wordline DAC code |
| bl_code | output | VW | Bitline DAC code |
| sl_code | output | VW | Source-line DAC code |

## Verification
Several decisions fall on the same verify acknowledge. A passing result can arrive on the very last search point, in the same cycle in which the exhaustion test would declare failure. The bench sets up a RESET run whose comparator passes exactly on the final attempt and expects done with fail low. It also runs the same ranges with no pass at all and expects fail. The wordline wrap and the line step share one cycle as well. A FORM search that passes several attempts into the second line value is logged attempt by attempt and checked against the expected sequence of voltage points.

// File: rtl/rram_pv_seq.sv
module rram_pv_seq #(
  parameter int VW = 8,
  parameter int CW = 16,
  parameter logic [VW-1:0] STEP = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    op,
  input  logic [VW-1:0] wl_min,
  input  logic [VW-1:0] wl_max,
  input  logic [VW-1:0] ln_min,
  input  logic [VW-1:0] ln_max,
  input  logic [CW-1:0] pulse_len,
  input  logic          vfy_ack,
  input  logic          vfy_lrs,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic          pulse,
  output logic          vfy_req,
  output logic [VW-1:0] wl_code,
  output logic [VW-1:0] bl_code,
  output logic [VW-1:0] sl_code
);
  localparam logic [1:0] OP_RESET = 2'd2;
  localparam logic [1:0] OP_NONE  = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_PULSE, S_VFY} st_t;

  st_t           st_q;
  logic [1:0]    op_q;
  logic [VW-1:0] wl_q, ln_q;
  logic [CW-1:0] cnt_q;
  logic          done_q, fail_q;

  wire          go      = (st_q == S_IDLE) && start && (op != OP_NONE);
  wire          is_rst  = (op_q == OP_RESET);
  wire          pass    = vfy_lrs ^ is_rst;
  wire [VW:0]   wl_nx   = {1'b0, wl_q} + {1'b0, STEP};
  wire [VW:0]   ln_nx   = {1'b0, ln_q} + {1'b0, STEP};
  wire          wl_more = wl_nx <= {1'b0, wl_max};
  wire          ln_more = ln_nx <= {1'b0, ln_max};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      op_q   <= '0;
      wl_q   <= '0;
      ln_q   <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: if (go) begin
          op_q   <= op;
          wl_q   <= wl_min;
          ln_q   <= ln_min;
          cnt_q  <= pulse_len;
          done_q <= 1'b0;
          fail_q <= 1'b0;
          st_q   <= S_PULSE;
        end
        S_PULSE: begin
          if (cnt_q <= 1) st_q <= S_VFY;
          else            cnt_q <= cnt_q - 1'b1;
        end
        S_VFY: if (vfy_ack) begin
          cnt_q <= pulse_len;
          if (pass) begin
            done_q <= 1'b1;
            st_q   <= S_IDLE;
          end else if (wl_more) begin
            wl_q <= wl_nx[VW-1:0];
            st_q <= S_PULSE;
          end else if (ln_more) begin
            ln_q <= ln_nx[VW-1:0];
            wl_q <= wl_min;
            st_q <= S_PULSE;
          end else begin
            done_q <= 1'b1;
            fail_q <= 1'b1;
            st_q   <= S_IDLE;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy    = (st_q != S_IDLE);
  assign pulse   = (st_q == S_PULSE);
  assign vfy_req = (st_q == S_VFY);
  assign done    = done_q;
  assign fail    = fail_q;
  assign wl_code = wl_q;
  assign bl_code = is_rst ? '0 : ln_q;
  assign sl_code = is_rst ? ln_q : '0;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    vfy_req |=> (vfy_req || $past(vfy_ack))); // R4
  AST_CODES_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && $past(pulse)) |-> ($stable(wl_code) && $stable(bl_code) && $stable(sl_code))); // R4
  AST_REQ_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulse) |-> vfy_req); // R3
  AST_FAIL_HAS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> done); // R8
  AST_BUSY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!done && !fail)); // R11
  AST_NEXT_POINT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(vfy_req) && pulse) |-> ((wl_code == $past(wl_code) + STEP) || (wl_code == wl_min))); // R6
endmodule

// File: tb/test_rram_pv_seq.sv
module test_rram_pv_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [1:0] op = 2'd0;
  logic [7:0] wl_min = 0, wl_max = 0, ln_min = 0, ln_max = 0;
  logic [15:0] pulse_len = 16'd1;
  logic       vfy_ack = 1'b0;
  logic       vfy_lrs = 1'b0;
  logic       busy, done, fail, pulse, vfy_req;
  logic [7:0] wl_code, bl_code, sl_code;

  int total = 0;
  int bad = 0;

  int rec_n = 0;
  int vcount = 0;
  int pass_at = -1;
  bit good_lrs = 1'b1;
  bit prev_pulse = 1'b0;
  int rec_wl [0:63];
  int rec_bl [0:63];
  int rec_sl [0:63];
  int rec_pw [0:63];

  always #2.5 clk = ~clk;

  rram_pv_seq i_rram_pv_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op),
    .wl_min(wl_min), .wl_max(wl_max), .ln_min(ln_min), .ln_max(ln_max),
    .pulse_len(pulse_len), .vfy_ack(vfy_ack), .vfy_lrs(vfy_lrs),
    .busy(busy), .done(done), .fail(fail), .pulse(pulse), .vfy_req(vfy_req),
    .wl_code(wl_code), .bl_code(bl_code), .sl_code(sl_code)
  );

  always @(negedge clk) begin
    if (pulse && !prev_pulse) begin
      if (rec_n < 64) begin
        rec_wl[rec_n] = int'(wl_code);
        rec_bl[rec_n] = int'(bl_code);
        rec_sl[rec_n] = int'(sl_code);
        rec_pw[rec_n] = 1;
      end
      rec_n = rec_n + 1;
    end else if (pulse && rec_n > 0 && rec_n <= 64) begin
      rec_pw[rec_n-1] = rec_pw[rec_n-1] + 1;
    end
    prev_pulse = pulse;
    if (vfy_req && !vfy_ack) begin
      vfy_lrs = (vcount == pass_at) ? good_lrs : !good_lrs;
      vfy_ack = 1'b1;
      vcount = vcount + 1;
    end else begin
      vfy_ack = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [1:0] o);
    @(negedge clk);
    op = o;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic do_op(input logic [1:0] o, input int wmin, input int wmax,
                       input int lmin, input int lmax, input int plen,
                       input int pass_idx, input bit poke);
    int nw, nl, exp_n, exp_pw, li, wi;
    bit exp_fail;
    wl_min = 8'(wmin); wl_max = 8'(wmax);
    ln_min = 8'(lmin); ln_max = 8'(lmax);
    pulse_len = 16'(plen);
    pass_at = pass_idx;
    good_lrs = (o != 2'd2);
    rec_n = 0;
    vcount = 0;
    pulse_start(o);
    chk(busy && !done && !fail, "R11 start clears done", int'({busy, done, fail}), 4);
    if (poke) begin
      repeat (3) @(negedge clk);
      op = 2'd2;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      op = o;
    end
    for (int k = 0; k < 20000 && !done; k++) @(negedge clk);
    nw = wmax - wmin + 1;
    nl = lmax - lmin + 1;
    exp_fail = (pass_idx < 0);
    exp_n = exp_fail ? nw * nl : pass_idx + 1;
    exp_pw = (plen == 0) ? 1 : plen;
    chk(rec_n == exp_n, "R6 R7 attempt count", rec_n, exp_n);
    for (int i = 0; i < exp_n && i < rec_n && i < 64; i++) begin
      li = lmin + i / nw;
      wi = wmin + i % nw;
      chk(rec_wl[i] == wi, "R6 R7 wordline code", rec_wl[i], wi);
      if (o == 2'd2) begin
        chk(rec_sl[i] == li && rec_bl[i] == 0, "R2 reset drives source line", rec_sl[i], li);
      end else begin
        chk(rec_bl[i] == li && rec_sl[i] == 0, "R2 form/set drives bitline", rec_bl[i], li);
      end
      chk(rec_pw[i] == exp_pw, "R3 pulse width", rec_pw[i], exp_pw);
    end
    chk(done == 1'b1 && busy == 1'b0, "R5 completion", int'({done, busy}), 2);
    chk(fail == exp_fail, exp_fail ? "R8 fail on exhaustion" : "R9 pass without fail",
        int'(fail), int'(exp_fail));
    li = lmin + (exp_n - 1) / nw;
    wi = wmin + (exp_n - 1) % nw;
    chk(int'(wl_code) == wi, "R8 R9 final wordline held", int'(wl_code), wi);
    chk(int'((o == 2'd2) ? sl_code : bl_code) == li, "R8 R9 final line held",
        int'((o == 2'd2) ? sl_code : bl_code), li);
  endtask

  task automatic t_reset;
    chk(!busy && !done && !fail && !pulse && !vfy_req, "R1 reset flags",
        int'({busy, done, fail, pulse, vfy_req}), 0);
    chk(wl_code == 0 && bl_code == 0 && sl_code == 0, "R1 reset codes",
        int'(wl_code) + int'(bl_code) + int'(sl_code), 0);
  endtask

  task automatic t_form_search;
    do_op(2'd0, 14, 20, 26, 31, 200, 9, 1'b0);
  endtask

  task automatic t_set_single;
    do_op(2'd1, 17, 17, 24, 24, 0, 0, 1'b0);
    chk(rec_n == 1, "R12 single attempt", rec_n, 1);
  endtask

  task automatic t_reset_exhaust;
    do_op(2'd2, 25, 26, 24, 25, 3, -1, 1'b0);
    chk(bl_code == 0, "R2 reset bitline zero", int'(bl_code), 0);
  endtask

  task automatic t_reset_last_pass;
    do_op(2'd2, 25, 26, 24, 25, 3, 3, 1'b0);
  endtask

  task automatic t_ignore_and_hold;
    do_op(2'd1, 10, 12, 20, 20, 5, -1, 1'b1);
    chk(rec_sl[0] == 0 && rec_n == 3, "R10 start while busy ignored", rec_n, 3);
    repeat (5) @(negedge clk);
    chk(done && fail, "R11 done held", int'({done, fail}), 3);
    pulse_start(2'd3);
    @(negedge clk);
    chk(!busy && done && fail, "R10 op 3 ignored", int'({busy, done, fail}), 3);
    chk(!pulse, "R10 no pulse for op 3", int'(pulse), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_form_search();
    t_set_single();
    t_reset_exhaust();
    t_reset_last_pass();
    t_ignore_and_hold();
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule